// File: doc/BRIEF.md
# Flash, Blink and Brightness Attribute Timer

This block decides, cycle by cycle, which of the eight character positions of a multiplexed dot-matrix LED display may drive light. It takes the attribute bits of the display's control register and the eight per-character flash bits, and it produces an eight-bit enable, one bit per character position, plus the brightness gate that the column drivers use to set the duty cycle.

Inside, a free-running divider from the display clock sets a slow on/off state. At the default setting the state changes every 14,336 clocks, so one full on/off period lasts 28,672 clocks. A second counter steps through a 15-step sub-cycle, and the brightness code picks how many of those steps are lit. Whole-display blink takes priority over per-character flash. Reset returns both counters to a fixed starting point. Several displays that share one clock and one reset therefore flash and blink in step.

Top module: `attr_timer`

## Requirements
- R1: In the first cycle after reset is released, the sub-cycle step is 0 and the on/off state is "on". With a clear attribute word every digit enable and the brightness gate are then 1.
- R2: The on/off state is "on" for clock counts 0 to 14,335 after reset and "off" for 14,336 to 28,671, and this repeats with a period of 28,672 clocks.
- R3: The brightness gate is high in the first T steps of every 15-clock sub-cycle. The code in attribute bits 2:0 sets T: 0→15, 1→12, 2→8, 3→6, 4→4, 5→3, 6→2.
- R4: Brightness code 7 blanks the display: the gate and every digit enable stay 0.
- R5: When attribute bit 3 (flash) is 1 and bit 4 is 0, a digit whose flash bit is 1 follows the on/off state. Digits whose flash bit is 0 stay on.
- R6: When attribute bits 3 and 4 are both 0, the flash bits have no effect on any digit enable.
- R7: When attribute bit 4 (blink) is 1, all eight digits follow the on/off state together, whatever bit 3 and the flash bits hold.
- R8: Each digit enable is its on/off decision ANDed with the brightness gate.
- R9: Asserting reset in mid-run restarts both counters, so the next run begins in the "on" state at step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset of the counters |
| attr_word | input | 5 | Bit 4 blink, bit 3 flash, bits 2:0 brightness code |
| flash_bits | input | 8 | Per-digit flash bits, bit i for digit i |
| digit_en | output | 8 | Per-digit light enable |
| bright_gate | output | 1 | Brightness duty-cycle gate |

## Verification
Both outputs are combinational functions of registered counters and the present inputs. An input change is therefore visible in the same cycle, and a counter advance is visible right after the clock edge that causes it. The bench counts the edges seen since the last reset. From that count and the current inputs it computes the expected enables and gate, and it compares them on every falling edge. It drives the inputs just after the rising edge, so each compare sees settled values. Single checks are placed at counts 14,335 and 14,336, where the on/off state flips, and at the first cycle after a reset in mid-run.

// File: rtl/attr_timer_pkg.sv
package attr_timer_pkg;

  localparam int unsigned SUB_STEPS = 15;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned STEP_W    = $clog2(SUB_STEPS);

  // lit steps per sub-cycle for each brightness code
  function automatic logic [STEP_W-1:0] lit_steps(input logic [CODE_W-1:0] code);
    logic [STEP_W-1:0] t;
    case (code)
      3'd0:    t = STEP_W'(15);
      3'd1:    t = STEP_W'(12);
      3'd2:    t = STEP_W'(8);
      3'd3:    t = STEP_W'(6);
      3'd4:    t = STEP_W'(4);
      3'd5:    t = STEP_W'(3);
      3'd6:    t = STEP_W'(2);
      default: t = STEP_W'(0);
    endcase
    return t;
  endfunction

  // on/off decision for one digit
  function automatic logic digit_on(input logic blink, input logic flash,
                                    input logic fbit, input logic phase_on);
    logic r;
    if (blink)              r = phase_on;
    else if (flash && fbit) r = phase_on;
    else                    r = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/attr_rate_divider.sv
module attr_rate_divider #(
  parameter int unsigned HALF_PERIOD = 14336
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_on,
  output logic half_wrap
);
  localparam int unsigned CNT_W = $clog2(HALF_PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign half_wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_on <= 1'b1;
    end else if (half_wrap) begin
      cnt      <= '0;
      phase_on <= ~phase_on;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_flip_only_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_on != $past(phase_on)) |-> ($past(cnt) == LAST));

  p_wrap_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_wrap |=> (cnt == '0));

endmodule

// File: rtl/bright_pwm.sv
module bright_pwm
  import attr_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              gate,
  output logic              step_wrap
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SUB_STEPS - 1);

  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] thresh;

  assign thresh    = lit_steps(code);
  assign step_wrap = (step == LAST_STEP);
  assign gate      = (step < thresh);

  always_ff @(posedge clk) begin
    if (!rst_n)         step <= '0;
    else if (step_wrap) step <= '0;
    else                step <= step + 1'b1;
  end

  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST_STEP);

  p_full_code_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |-> gate);

  p_blank_code_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '1) |-> !gate);

endmodule

// File: rtl/digit_gate.sv
module digit_gate
  import attr_timer_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blink_en,
  input  logic              flash_en,
  input  logic [DIGITS-1:0] flash_bits,
  input  logic              phase_on,
  input  logic              gate,
  output logic [DIGITS-1:0] digit_en
);
  logic [DIGITS-1:0] attr_on;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign attr_on[i]  = digit_on(blink_en, flash_en, flash_bits[i], phase_on);
    assign digit_en[i] = attr_on[i] & gate;
  end

  p_needs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|digit_en) |-> gate);

  p_blink_all_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blink_en |-> (digit_en == '0 || digit_en == '1));

  p_flash_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_en && !flash_en) |-> (digit_en == {DIGITS{gate}}));

  p_flashing_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_en && !blink_en && !phase_on) |-> ((digit_en & flash_bits) == '0));

endmodule

// File: rtl/attr_timer.sv
module attr_timer
  import attr_timer_pkg::*;
#(
  parameter int unsigned DIGITS      = 8,
  parameter int unsigned HALF_PERIOD = 14336
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        attr_word,
  input  logic [DIGITS-1:0] flash_bits,
  output logic [DIGITS-1:0] digit_en,
  output logic              bright_gate
);
  localparam int unsigned BLINK_BIT = 4;
  localparam int unsigned FLASH_BIT = 3;

  logic phase_on;
  logic half_wrap;
  logic step_wrap;
  logic blink_en;
  logic flash_en;
  logic [CODE_W-1:0] bright_code;

  assign blink_en    = attr_word[BLINK_BIT];
  assign flash_en    = attr_word[FLASH_BIT];
  assign bright_code = attr_word[CODE_W-1:0];

  attr_rate_divider #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_on  (phase_on),
    .half_wrap (half_wrap)
  );

  bright_pwm u_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (bright_code),
    .gate      (bright_gate),
    .step_wrap (step_wrap)
  );

  digit_gate #(.DIGITS(DIGITS)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .blink_en   (blink_en),
    .flash_en   (flash_en),
    .flash_bits (flash_bits),
    .phase_on   (phase_on),
    .gate       (bright_gate),
    .digit_en   (digit_en)
  );

  // both counters leave reset together and wrap on their own schedules
  p_restart_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (phase_on && bright_gate == (bright_code != '1)));

  p_no_early_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (half_wrap && step_wrap) |-> (phase_on == $past(phase_on)));

endmodule

// File: tb/tb_attr_timer.sv
`timescale 1ns/1ps
module tb_attr_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] attr_word = '0;
  logic [7:0] flash_bits = '0;
  logic [7:0] digit_en;
  logic       bright_gate;

  int vectors = 0;
  int miscompares = 0;
  int n = 0;
  bit armed = 0;
  string req_tag = "R1";

  always #2 clk = ~clk;

  attr_timer dut (
    .clk(clk), .rst_n(rst_n), .attr_word(attr_word),
    .flash_bits(flash_bits), .digit_en(digit_en), .bright_gate(bright_gate)
  );

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  function automatic int lit_of(int code);
    int table_lit[8] = '{15, 12, 8, 6, 4, 3, 2, 0};
    return table_lit[code];
  endfunction

  function automatic bit exp_gate(int cnt, logic [4:0] a);
    return (cnt % 15) < lit_of(int'(a[2:0]));
  endfunction

  function automatic logic [7:0] exp_en(int cnt, logic [4:0] a, logic [7:0] f);
    bit on_phase;
    logic [7:0] sel;
    on_phase = ((cnt / 14336) % 2) == 0;
    if (a[4])      sel = 8'hFF;
    else if (a[3]) sel = f;
    else           sel = 8'h00;
    return (on_phase ? 8'hFF : ~sel) & {8{exp_gate(cnt, a)}};
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at count %0d: got en=%h gate=%b, expected en=%h gate=%b",
               tag, n, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  always @(negedge clk) begin
    if (armed && rst_n)
      check(req_tag, {digit_en, bright_gate},
            {exp_en(n, attr_word, flash_bits), exp_gate(n, attr_word)});
  end

  task automatic step_cycles(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wait_count(int target);
    while (n != target) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    step_cycles(4);
    rst_n = 1'b1;
    armed = 1;
    // R1: first cycle after release, all lit at full brightness
    @(negedge clk);
    check("R1", {digit_en, bright_gate}, {8'hFF, 1'b1});

    // R3 / R4 brightness sweep
    @(posedge clk); #1;
    for (int c = 0; c < 8; c++) begin
      req_tag = (c == 7) ? "R4" : "R3";
      attr_word = 5'(c);
      step_cycles(45);
    end
    attr_word = 5'd7;
    flash_bits = 8'hFF;
    req_tag = "R4";
    step_cycles(20);

    // R5 flash with mixed mask across the first flip
    attr_word = 5'b01000;
    flash_bits = 8'hA5;
    req_tag = "R5";
    wait_count(14335);
    @(negedge clk);
    check("R2", {digit_en, bright_gate}, {8'hFF, 1'b1});
    @(negedge clk);
    check("R2", {digit_en, bright_gate}, {8'h5A, 1'b1});
    @(posedge clk); #1;
    step_cycles(16000);

    // R6 flash bits ignored while flash disabled, spanning an off window
    attr_word = 5'b00001;
    flash_bits = 8'hFF;
    req_tag = "R6";
    step_cycles(30000);

    // R7 blink overrides flash
    attr_word = 5'b11000;
    flash_bits = 8'h0F;
    req_tag = "R7";
    step_cycles(30000);

    // R8 blink with reduced brightness
    attr_word = 5'b10010;
    flash_bits = 8'h00;
    req_tag = "R8";
    step_cycles(2000);

    // R9 mid-run reset, currently in some phase; restart must be on
    attr_word = 5'b11000;
    flash_bits = 8'hFF;
    wait_count(14336 * 7 + 100);
    @(negedge clk);
    check("R9", {digit_en, bright_gate}, {8'h00, 1'b1});
    @(posedge clk); #1;
    rst_n = 1'b0;
    step_cycles(3);
    rst_n = 1'b1;
    req_tag = "R9";
    @(negedge clk);
    check("R9", {digit_en, bright_gate}, {8'hFF, 1'b1});
    @(posedge clk); #1;
    step_cycles(200);
    finish_run();
  end
endmodule